// File: doc/BRIEF.md
# Supply Supervisor Reset Sequencer

This block produces the reset for a processor from two digital status inputs. The first is a supply-good flag that comes from an external threshold comparator. It is high while the supply is above its threshold. The second is a request from a push button or from other logic to reset the processor. Both inputs are asynchronous to the block's clock. Each passes through its own two-flop synchronizer before the logic uses it.

The block holds reset while the supply is low or while the manual request is active. It keeps reset asserted for a programmed hold time after the last cycle in which either input was active. Any new supply dip or manual request during an active reset restarts the hold time in full. This restart is how the minimum pulse width debounces a mechanical switch: every bounce only lengthens the pulse.

The hold time is given in milliseconds and converted to clock cycles from a clock-frequency parameter. The reset leaves the block on two outputs, an active-low one and an active-high one, and each output comes from its own register.

Top module: `supv_reset_seq`

## Requirements
- R1: While the logic's own power-on reset `porN` is low, `rstOutN` is 0 and `rstOut` is 1. Both outputs are still in this asserted state on the first clock edge after `porN` rises.
- R2: When `supplyOk` is 0 or `manualRst` is 1 as seen after synchronization, reset is asserted (`rstOutN` = 0) on the following clock edge.
- R3: Reset is released (`rstOutN` rises) exactly HOLD_CYC clock edges after the last edge at which the logic saw an active synchronized input. HOLD_CYC = CLK_HZ/1000 × effective hold time in ms.
- R4: The effective hold time is HOLD_MS, which defaults to 200 ms. If HOLD_MS is set below MIN_HOLD_MS (140 ms), the effective hold time is MIN_HOLD_MS.
- R5: A supply dip that arrives while a reset pulse is running restarts the full hold time. Reset is then released HOLD_CYC edges after the dip ends, never sooner.
- R6: A manual-reset request starts a reset pulse, even if it lasts only a single clock cycle. Further requests (bounces) during the pulse each restart the hold time.
- R7: `rstOut` is always the exact inverse of `rstOutN`.
- R8: Each input passes through a two-flop synchronizer. An input change made between edges e-1 and e reaches the reset outputs at edge e+2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock, frequency CLK_HZ |
| porN | input | 1 | Asynchronous active-low power-on reset of the block's own logic |
| supplyOk | input | 1 | Supply-good flag from the external comparator: 1 = above threshold |
| manualRst | input | 1 | Manual reset request, active high, asynchronous |
| rstOutN | output | 1 | Processor reset, active low |
| rstOut | output | 1 | Processor reset, active high, the inverse of rstOutN |

## Verification
The bench goes after dips and manual pulses that arrive partway through a running hold period. A design that resumed the counter instead of restarting it would release reset early, and the cycle-exact reference model catches that release. Single-cycle pulses on both inputs check that the synchronizers sample every cycle; a design that missed them would never assert reset. A second instance whose hold time is set below the minimum checks the clamp, because a design without the clamp would release that instance after 50 cycles instead of 140. Every clock also compares the two output polarities, which catches any skew between the two output registers.

// File: rtl/supv_pkg.sv
package supv_pkg;

  // Strobes from the control FSM to the hold-counter datapath
  typedef struct packed {
    logic clr;  // reload the hold counter to zero
    logic inc;  // advance the hold counter by one
  } holdStrobe_t;

  typedef enum logic {
    ST_HOLD = 1'b0,  // reset asserted, hold time running or restarting
    ST_RUN  = 1'b1   // reset released
  } supvState_t;

endpackage

// File: rtl/supv_sync.sv
module supv_sync #(
  parameter int WIDTH   = 2,
  parameter int STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             porN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [WIDTH-1:0] stage [STAGES];

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) stage[0] <= RST_VAL;
    else       stage[0] <= asyncIn;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge porN) begin
      if (!porN) stage[s] <= RST_VAL;
      else       stage[s] <= stage[s-1];
    end
  end

  assign syncOut = stage[STAGES-1];

endmodule

// File: rtl/supv_hold_dp.sv
module supv_hold_dp
  import supv_pkg::*;
#(
  parameter int HOLD_CYC = 200,
  localparam int CNT_W   = $clog2(HOLD_CYC + 1)
) (
  input  logic             clk,
  input  logic             porN,
  input  holdStrobe_t      strobe,
  output logic [CNT_W-1:0] holdCnt,
  output logic             holdDone
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(HOLD_CYC - 1);

  always_ff @(posedge clk or negedge porN) begin
    if (!porN)           holdCnt <= '0;
    else if (strobe.clr) holdCnt <= '0;
    else if (strobe.inc) holdCnt <= holdCnt + CNT_W'(1);
  end

  // Last counting cycle: the release happens on this edge
  assign holdDone = (holdCnt == LAST);

endmodule

// File: rtl/supv_ctrl.sv
module supv_ctrl
  import supv_pkg::*;
(
  input  logic        clk,
  input  logic        porN,
  input  logic        trig,
  input  logic        holdDone,
  output holdStrobe_t strobe,
  output logic        rstOutN,
  output logic        rstOut
);

  supvState_t state, stateNxt;

  always_comb begin
    stateNxt   = state;
    strobe.clr = 1'b0;
    strobe.inc = 1'b0;
    unique case (state)
      ST_HOLD: begin
        if (trig)          strobe.clr = 1'b1;
        else if (holdDone) stateNxt   = ST_RUN;
        else               strobe.inc = 1'b1;
      end
      ST_RUN: begin
        if (trig) begin
          strobe.clr = 1'b1;
          stateNxt   = ST_HOLD;
        end
      end
      default: stateNxt = ST_HOLD;
    endcase
  end

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      state   <= ST_HOLD;
      rstOutN <= 1'b0;
      rstOut  <= 1'b1;
    end else begin
      state   <= stateNxt;
      rstOutN <= (stateNxt == ST_RUN);
      rstOut  <= (stateNxt != ST_RUN);
    end
  end

endmodule

// File: rtl/supv_reset_seq.sv
module supv_reset_seq #(
  parameter int CLK_HZ      = 50_000_000,
  parameter int HOLD_MS     = 200,
  parameter int MIN_HOLD_MS = 140
) (
  input  logic clk,
  input  logic porN,
  input  logic supplyOk,
  input  logic manualRst,
  output logic rstOutN,
  output logic rstOut
);
  import supv_pkg::*;

  localparam int EFF_MS   = (HOLD_MS < MIN_HOLD_MS) ? MIN_HOLD_MS : HOLD_MS;
  localparam int HOLD_CYC = (CLK_HZ / 1000) * EFF_MS;
  localparam int CNT_W    = $clog2(HOLD_CYC + 1);

  logic [1:0]       syncVec;
  logic             supOkSync, mrSync, trig, holdDone;
  logic [CNT_W-1:0] holdCnt;
  holdStrobe_t      strobe;

  // bit 1: supply good (resets to "bad"), bit 0: manual request
  supv_sync #(.WIDTH(2), .STAGES(2), .RST_VAL(2'b00)) sync_i (
    .clk(clk), .porN(porN),
    .asyncIn({supplyOk, manualRst}),
    .syncOut(syncVec)
  );

  assign supOkSync = syncVec[1];
  assign mrSync    = syncVec[0];
  assign trig      = !supOkSync || mrSync;

  supv_ctrl ctrl_i (
    .clk(clk), .porN(porN), .trig(trig), .holdDone(holdDone),
    .strobe(strobe), .rstOutN(rstOutN), .rstOut(rstOut)
  );

  supv_hold_dp #(.HOLD_CYC(HOLD_CYC)) dp_i (
    .clk(clk), .porN(porN), .strobe(strobe),
    .holdCnt(holdCnt), .holdDone(holdDone)
  );

endmodule

// File: rtl/supv_reset_seq_chk.sv
module supv_reset_seq_chk #(
  parameter int CNT_W    = 8,
  parameter int HOLD_CYC = 200
) (
  input logic             clk,
  input logic             porN,
  input logic             supOkSync,
  input logic             mrSync,
  input logic             holdDone,
  input logic [CNT_W-1:0] holdCnt,
  input logic             rstOutN,
  input logic             rstOut
);

  // R2: synchronized low supply forces reset on the next edge
  a_r2_supply_low: assert property (@(posedge clk) disable iff (!porN)
    !supOkSync |=> !rstOutN);

  // R6: synchronized manual request forces reset on the next edge
  a_r6_manual: assert property (@(posedge clk) disable iff (!porN)
    mrSync |=> !rstOutN);

  // R3: release only after the datapath reported its last hold cycle
  a_r3_release_at_done: assert property (@(posedge clk) disable iff (!porN)
    $rose(rstOutN) |-> $past(holdDone));

  // R5: an active input restarts the hold counter
  a_r5_restart: assert property (@(posedge clk) disable iff (!porN)
    (!supOkSync || mrSync) |=> (holdCnt == '0));

  // R3: the counter never runs past the hold length
  a_r3_cnt_bound: assert property (@(posedge clk) disable iff (!porN)
    holdCnt <= CNT_W'(HOLD_CYC - 1));

  // R7: the two output registers always disagree
  a_r7_polarity: assert property (@(posedge clk) disable iff (!porN)
    rstOut == !rstOutN);

endmodule

bind supv_reset_seq supv_reset_seq_chk #(.CNT_W(CNT_W), .HOLD_CYC(HOLD_CYC)) chk_i (
  .clk(clk), .porN(porN), .supOkSync(supOkSync), .mrSync(mrSync),
  .holdDone(holdDone), .holdCnt(holdCnt), .rstOutN(rstOutN), .rstOut(rstOut)
);

// File: tb/supv_reset_seq_tb_top.sv
`timescale 1ns/1ps
module supv_reset_seq_tb_top;

  localparam int CLK_HZ   = 1000;     // one cycle per ms keeps runs short
  localparam int HOLD_A   = 200;      // default hold time
  localparam int HOLD_B   = 140;      // expected clamp for HOLD_MS=50

  logic clk = 1'b0;
  logic porN = 1'b0;
  logic supplyOk = 1'b0;
  logic manualRst = 1'b0;
  logic rstOutN, rstOut, rstOutNB, rstOutB;

  int total = 0;
  int bad = 0;
  string phase = "R1 power-on";
  bit running = 1'b1;

  always #5 clk = ~clk;

  supv_reset_seq #(.CLK_HZ(CLK_HZ)) dut_i (
    .clk(clk), .porN(porN), .supplyOk(supplyOk), .manualRst(manualRst),
    .rstOutN(rstOutN), .rstOut(rstOut)
  );

  supv_reset_seq #(.CLK_HZ(CLK_HZ), .HOLD_MS(50)) dut_min (
    .clk(clk), .porN(porN), .supplyOk(supplyOk), .manualRst(manualRst),
    .rstOutN(rstOutNB), .rstOut(rstOutB)
  );

  // Behavioural reference: input delay line plus "quiet cycles" counters
  bit supQ[$];
  bit mrQ[$];
  int quietA = 0, quietB = 0;
  bit expA = 1'b0, expB = 1'b0;

  always @(posedge clk) begin
    if (!porN) begin
      supQ = '{1'b0, 1'b0};
      mrQ  = '{1'b0, 1'b0};
      quietA = 0; quietB = 0;
    end else begin
      bit act;
      act = !supQ[0] || mrQ[0];
      void'(supQ.pop_front()); void'(mrQ.pop_front());
      supQ.push_back(supplyOk); mrQ.push_back(manualRst);
      if (act) begin quietA = 0; quietB = 0; end
      else begin
        if (quietA < HOLD_A) quietA++;
        if (quietB < HOLD_B) quietB++;
      end
    end
    expA = (quietA >= HOLD_A);
    expB = (quietB >= HOLD_B);
  end

  task automatic check(string tag, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  // Compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (running) begin
      check(phase, rstOutN, expA);
      check("R7 polarity", rstOut, ~rstOutN);
      check("R4 clamped hold", rstOutNB, expB);
      check("R7 polarity clamped", rstOutB, ~rstOutNB);
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    cyc(4);
    check("R1 reset state low", rstOutN, 1'b0);
    check("R1 reset state high", rstOut, 1'b1);
    porN = 1'b1;
    cyc(1);
    check("R1 after por release", rstOutN, 1'b0);

    phase = "R3 power-up release";
    cyc(20);
    supplyOk = 1'b1;
    cyc(260);
    check("R3 released after hold", rstOutN, 1'b1);

    phase = "R2 brownout";
    supplyOk = 1'b0;
    cyc(1); supplyOk = 1'b1;
    cyc(1);
    check("R8 not yet visible", rstOutN, 1'b1);
    cyc(1);
    check("R8 visible at third edge", rstOutN, 1'b0);

    phase = "R5 dip during pulse";
    cyc(100);
    supplyOk = 1'b0; cyc(3); supplyOk = 1'b1;
    cyc(150);
    check("R5 still held after restart", rstOutN, 1'b0);
    cyc(100);
    check("R5 released", rstOutN, 1'b1);

    phase = "R6 manual bounce";
    manualRst = 1'b1; cyc(2); manualRst = 1'b0;
    cyc(50); manualRst = 1'b1; cyc(1); manualRst = 1'b0;
    cyc(40); manualRst = 1'b1; cyc(3); manualRst = 1'b0;
    cyc(180);
    check("R6 bounce extends pulse", rstOutN, 1'b0);
    cyc(60);
    check("R6 released", rstOutN, 1'b1);

    phase = "R6 single-cycle request";
    manualRst = 1'b1; cyc(1); manualRst = 1'b0;
    cyc(5);
    check("R6 short request caught", rstOutN, 1'b0);
    cyc(250);

    phase = "R2 supply held low";
    supplyOk = 1'b0; cyc(400);
    check("R2 held while low", rstOutN, 1'b0);
    supplyOk = 1'b1; cyc(250);

    phase = "R1 power-on mid-run";
    porN = 1'b0; cyc(3);
    check("R1 por forces reset", rstOutN, 1'b0);
    porN = 1'b1; cyc(260);
    check("R3 release after por", rstOutN, 1'b1);

    running = 1'b0;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #200000000;
    bad++; total++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule